// File: doc/BRIEF.md
# Cascaded Odd-Even Post Divider

This block divides a fast input clock by the product of three programmable moduli. Two stages each take a 4-bit setting. A code N selects division by N+1. The third stage takes a 2-bit setting that selects a power of two. The output clock keeps a nominal 50 percent duty cycle for every total modulus, odd ones included. To do this the output is shaped on both edges of the input clock, which gives half-cycle resolution.

All three stage counters run in the input clock domain. Each stage advances when the stage below it wraps, so together the counters form one mixed-radix position counter. Each stage decides whether the combined position lies in the first half of the total period. An odd stage passes the tie at its midpoint down to the next lower stage. A final shaper turns that decision into the output waveform. Codes 12 to 15 on a 4-bit field are not legal settings. They are forced to divide by 12 and flagged. The settings are expected to be static, or changed only while reset is held.

Top module: `post_div_chain`

## Requirements
- R1: After reset is released, `clk_out` repeats with a period of exactly M input cycles, where M is the product of the three stage moduli.
- R2: On `code_a` and `code_b`, a code value N from 0 to 11 gives a stage modulus of N+1, so the range is 1 to 12.
- R3: On `code_c`, the values 0, 1, 2 and 3 give stage moduli of 1, 2, 4 and 8.
- R4: Within each period, `clk_out` is high for exactly M half-cycles of `clk_in`, for both odd and even M.
- R5: When all three moduli are 1, `clk_out` follows `clk_in`: it is high in the first half of every input cycle after reset is released.
- R6: A value of 12 to 15 on `code_a` or `code_b` sets that stage to divide by 12 and drives `cfg_err` high. While both fields are 11 or lower, `cfg_err` is low.
- R7: While `rst_n` is low, `clk_out` is low. The first high phase starts at the first rising edge of `clk_in` that samples `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| code_a | input | 4 | First stage setting, modulus = code + 1 |
| code_b | input | 4 | Second stage setting, modulus = code + 1 |
| code_c | input | 2 | Third stage setting, modulus = 2^code |
| clk_out | output | 1 | Divided clock, 50 percent duty |
| cfg_err | output | 1 | High when a 4-bit setting is outside 0..11 |

## Verification
The bench sweeps every legal combination of the three settings. It samples the output in the middle of every half-cycle and compares it with a model that only knows the period M and the high time of M half-cycles.

Combinations where every stage is odd show whether the half-cycle stretch is applied. Combinations with an even stage anywhere in the chain show that the stretch is not applied to even totals. The all-ones combination separates the bypass path from the counters.

Out-of-range settings on each 4-bit field, alone and together, show the clamp to 12 and the flag. The first two samples after every release check the fixed start phase.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
// Shared widths and limits for the cascaded post divider.
// Assumes the two wide stages share one code width and one modulus limit.
package pdiv_pkg;
    localparam int WIDE_CODE_W = 4;   // code width of stages one and two
    localparam int POW_CODE_W  = 2;   // code width of stage three
    localparam int WIDE_LIMIT  = 12;  // largest legal modulus of a wide stage
    localparam int NUM_STAGES  = 3;
    localparam int NUM_WIDE    = 2;
    localparam int POW_MAX     = 1 << ((1 << POW_CODE_W) - 1);
    localparam int MOD_MAX     = (WIDE_LIMIT > POW_MAX) ? WIDE_LIMIT : POW_MAX;
    localparam int MOD_W       = $clog2(MOD_MAX + 1);
    typedef logic [MOD_W-1:0] mod_t;
endpackage

// File: rtl/pdiv_decode.sv
`timescale 1ns/1ps
// Turns a wide-stage code into its modulus (code + 1).
// Assumes codes at or above LIMIT are illegal: they clamp to LIMIT and are flagged.
module pdiv_decode #(
    parameter int CODE_W = 4,
    parameter int MOD_W  = 4,
    parameter int LIMIT  = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic [MOD_W-1:0]  modulus,
    output logic              bad
);
    // Range check and clamp of one setting field.
    always_comb begin
        bad     = (int'(code) >= LIMIT);
        modulus = bad ? MOD_W'(LIMIT) : MOD_W'(code) + MOD_W'(1);
    end
endmodule

// File: rtl/pdiv_stage.sv
`timescale 1ns/1ps
// One digit of the mixed-radix position counter.
// It advances when adv is high and wraps after modulus-1.
// hi says whether the position so far lies in the first half of the period.
// On an odd modulus, the midpoint digit defers to lower_hi from the stage below.
// Assumes modulus is at least 1 and is held static while running.
module pdiv_stage #(
    parameter int MOD_W = 4
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [MOD_W-1:0] modulus,
    input  logic             lower_hi,
    output logic             wrap,
    output logic             hi
);
    logic [MOD_W-1:0] idx;
    logic [MOD_W-1:0] half;
    logic             at_last;

    // Detect the last count and compare against the midpoint.
    always_comb begin
        half    = modulus >> 1;
        at_last = (idx == modulus - MOD_W'(1));
        wrap    = adv & at_last;
        hi      = (idx < half) | (modulus[0] & (idx == half) & lower_hi);
    end

    // Count input cycles (scaled by the stages below), wrapping at the modulus.
    always_ff @(posedge clk_in) begin
        if (!rst_n)
            idx <= '0;
        else if (adv)
            idx <= at_last ? '0 : idx + MOD_W'(1);
    end
endmodule

// File: rtl/pdiv_shaper.sv
`timescale 1ns/1ps
// Shapes the first-half decision into the output clock.
// Even totals use the rising-edge register alone. Odd totals OR it with a
// falling-edge copy, which stretches the high phase by half an input cycle.
// A total of one passes the input clock through once reset is released.
// Assumes odd_mode and bypass are static while running.
module pdiv_shaper (
    input  logic clk_in,
    input  logic rst_n,
    input  logic hi_top,
    input  logic odd_mode,
    input  logic bypass,
    output logic clk_out
);
    logic rise_q;
    logic fall_q;
    logic run_q;

    // Register the decision on the rising edge and note that reset has ended.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            rise_q <= hi_top;
            run_q  <= 1'b1;
        end
    end

    // Retime the registered decision by half a cycle.
    always_ff @(negedge clk_in) begin
        if (!rst_n)
            fall_q <= 1'b0;
        else
            fall_q <= rise_q;
    end

    // Select the output form for the configured total.
    always_comb begin
        if (bypass)
            clk_out = run_q & clk_in;
        else if (odd_mode)
            clk_out = rise_q | fall_q;
        else
            clk_out = rise_q;
    end
endmodule

// File: rtl/post_div_chain.sv
`timescale 1ns/1ps
// Three-stage post divider, total modulus = product of the stage moduli,
// with 50 percent duty for every total.
// Assumes the settings change only while rst_n is low.
module post_div_chain
    import pdiv_pkg::*;
(
    input  logic                  clk_in,
    input  logic                  rst_n,
    input  logic [WIDE_CODE_W-1:0] code_a,
    input  logic [WIDE_CODE_W-1:0] code_b,
    input  logic [POW_CODE_W-1:0]  code_c,
    output logic                  clk_out,
    output logic                  cfg_err
);
    logic [WIDE_CODE_W-1:0] wide_code [NUM_WIDE];
    mod_t                   stage_mod [NUM_STAGES];
    logic [NUM_WIDE-1:0]    wide_bad;
    logic [NUM_STAGES:0]    adv_chain;
    logic [NUM_STAGES:0]    hi_chain;
    logic [NUM_STAGES-1:0]  mod_is_one;
    logic [NUM_STAGES-1:0]  mod_is_odd;

    // Collect the wide-stage fields and derive the power-of-two modulus.
    always_comb begin
        wide_code[0] = code_a;
        wide_code[1] = code_b;
        stage_mod[NUM_STAGES-1] = mod_t'(1) << code_c;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_WIDE; g++) begin : g_dec
            pdiv_decode #(
                .CODE_W (WIDE_CODE_W),
                .MOD_W  (MOD_W),
                .LIMIT  (WIDE_LIMIT)
            ) u_dec (
                .code    (wide_code[g]),
                .modulus (stage_mod[g]),
                .bad     (wide_bad[g])
            );
        end

        for (g = 0; g < NUM_STAGES; g++) begin : g_stg
            pdiv_stage #(
                .MOD_W (MOD_W)
            ) u_stg (
                .clk_in   (clk_in),
                .rst_n    (rst_n),
                .adv      (adv_chain[g]),
                .modulus  (stage_mod[g]),
                .lower_hi (hi_chain[g]),
                .wrap     (adv_chain[g+1]),
                .hi       (hi_chain[g+1])
            );
            // Per-stage parity and unity flags for the shaper.
            always_comb begin
                mod_is_one[g] = (stage_mod[g] == mod_t'(1));
                mod_is_odd[g] = stage_mod[g][0];
            end
        end
    endgenerate

    // The lowest stage counts every cycle and sees no lower half-cycle.
    always_comb begin
        adv_chain[0] = 1'b1;
        hi_chain[0]  = 1'b0;
        cfg_err      = |wide_bad;
    end

    pdiv_shaper u_shape (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .hi_top   (hi_chain[NUM_STAGES]),
        .odd_mode (&mod_is_odd),
        .bypass   (&mod_is_one),
        .clk_out  (clk_out)
    );
endmodule

// File: rtl/post_div_chain_chk.sv
`timescale 1ns/1ps
// Property checker for post_div_chain, attached by bind below.
// It computes the total modulus from the port settings and tracks the cycle phase.
module post_div_chain_chk (
    input logic       clk_in,
    input logic       rst_n,
    input logic [3:0] code_a,
    input logic [3:0] code_b,
    input logic [1:0] code_c,
    input logic       clk_out,
    input logic       cfg_err
);
    int   tot;
    int   cyc      = 0;
    int   prev_j;
    logic armed    = 1'b0;
    logic low_seen = 1'b0;
    logic exp_late;

    // Expected total and expected level in the second half of the previous cycle.
    always_comb begin
        tot      = ((code_a > 4'd11) ? 12 : int'(code_a) + 1)
                 * ((code_b > 4'd11) ? 12 : int'(code_b) + 1)
                 * (1 << code_c);
        prev_j   = (cyc == 0) ? tot - 1 : cyc - 1;
        exp_late = (2 * prev_j + 1) < tot;
    end

    // Track the cycle index within the period since reset was released.
    always_ff @(posedge clk_in) begin
        low_seen <= !rst_n;
        if (!rst_n) begin
            cyc   <= 0;
            armed <= 1'b0;
        end else begin
            cyc   <= (cyc >= tot - 1) ? 0 : cyc + 1;
            armed <= 1'b1;
        end
    end

    AST_LATE_HALF: assert property (@(posedge clk_in) disable iff (!rst_n)
        armed |-> (clk_out == exp_late)); // R4
    AST_FIRST_PHASE: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($rose(rst_n) && tot > 1) |=> clk_out); // R7
    AST_ERR_SET: assert property (@(posedge clk_in) disable iff (!rst_n)
        (code_a > 4'd11 || code_b > 4'd11) |-> cfg_err); // R6
    AST_ERR_CLEAR: assert property (@(posedge clk_in) disable iff (!rst_n)
        (code_a <= 4'd11 && code_b <= 4'd11) |-> !cfg_err); // R6

    // Output stays low through a held reset.
    always @(negedge clk_in) begin
        if (!rst_n && low_seen)
            AST_RESET_LOW: assert (!clk_out); // R7
    end
endmodule

bind post_div_chain post_div_chain_chk u_chk (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .code_a  (code_a),
    .code_b  (code_b),
    .code_c  (code_c),
    .clk_out (clk_out),
    .cfg_err (cfg_err)
);

// File: tb/sim_post_div_chain.sv
`timescale 1ns/1ps
// Bench: sweeps all settings and compares every half-cycle against a period model.
module sim_post_div_chain;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [3:0] code_a = 4'd0;
    logic [3:0] code_b = 4'd0;
    logic [1:0] code_c = 2'd0;
    logic       clk_out;
    logic       cfg_err;
    int         vectors = 0;
    int         misses  = 0;

    post_div_chain u0 (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .code_a  (code_a),
        .code_b  (code_b),
        .code_c  (code_c),
        .clk_out (clk_out),
        .cfg_err (cfg_err)
    );

    always #4 clk_in = ~clk_in;

    task automatic check(input logic got, input logic exp, input string tag);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Hold reset, load the settings, release reset, then follow one period plus two cycles.
    task automatic run_case(input int ca, input int cb, input int cc, input string force_tag);
        int ma;
        int mb;
        int tot;
        logic err;
        ma  = (ca > 11) ? 12 : ca + 1;          // R2, R6 clamp
        mb  = (cb > 11) ? 12 : cb + 1;
        tot = ma * mb * (1 << cc);              // R3 power of two
        err = (ca > 11) || (cb > 11);
        @(posedge clk_in); #2;
        rst_n  = 1'b0;
        code_a = 4'(ca);
        code_b = 4'(cb);
        code_c = 2'(cc);
        repeat (2) @(posedge clk_in);
        #2;
        check(clk_out, 1'b0, "R7 low in reset");
        check(cfg_err, err, "R6 flag");
        rst_n = 1'b1;
        for (int h = 0; h < 2 * tot + 4; h++) begin
            string tag;
            if (h % 2 == 0) begin
                @(posedge clk_in); #2;
            end else begin
                #4;
            end
            if (force_tag != "")  tag = force_tag;
            else if (tot == 1)    tag = "R5 bypass";
            else if (h < 2)       tag = "R7 start phase";
            else                  tag = "R1 R2 R3 R4 period and duty";
            check(clk_out, logic'((h % (2 * tot)) < tot), tag);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk_in);
        // R2, R3: every legal combination of the three settings.
        for (int ca = 0; ca < 12; ca++)
            for (int cb = 0; cb < 12; cb++)
                for (int cc = 0; cc < 4; cc++)
                    run_case(ca, cb, cc, "");
        // R6: illegal settings clamp to 12 and raise the flag.
        run_case(13, 0, 0, "R6 clamp a");
        run_case(0, 15, 1, "R6 clamp b");
        run_case(12, 14, 0, "R6 clamp both");
        run_case(11, 11, 0, "R6 top legal");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(8 * 190000);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule